// File: doc/BRIEF.md
# SDRAM Line Burst Command Sequencer

This block turns a single four-beat cache-line request into the command stream for one SDRAM access. A request carries a direction flag, a byte address, byte enables and a whole line of write data. The sequencer opens the row with an activate command, then sends one column command per beat. The SDRAM's own burst feature is assumed to be off, so the sequencer steps the column address itself and wraps it inside the aligned 16-byte line. It closes the row with a precharge-all command.

A 2-bit latency field sets the delay from activate to the first column command, and read CAS latency uses the same value. On reads, each captured word is returned with a per-beat valid. On writes, data goes onto the bus in the same cycle as its column command, so a write burst ends earlier than a read burst. A new request may be accepted during the precharge cycle. Its activate is still held back until a configurable precharge-to-activate gap has elapsed.

Top module: `sdram_line_seq`

## Requirements
- R1: After reset and while idle the command pins {sdCsN,sdRasN,sdCasN,sdWeN} show NOP (0111), reqReady is 1, and sdDqOe, rdValid and doneP are 0.
- R2: An access starts with ACTV (0011) with the row, reqAddr[23:10], on sdAddr. The first column command comes exactly D cycles after ACTV. D comes from latField, sampled at acceptance: 00 gives 1, 01 gives 2, 10 and 11 give 3.
- R3: Four column commands, READ (0101) or WRITE (0100), are issued in consecutive cycles. Each carries column reqAddr[9:2] on sdAddr[7:0]. The two low column bits start at the requested word and advance by one per beat, modulo 4.
- R4: The word on sdDqIn D cycles after each READ is returned on rdData with rdValid high in the following cycle, in beat order.
- R5: On a read, PALL (0010) with sdAddr[10]=1 and all other sdAddr bits 0 is issued exactly 2D+4 cycles after ACTV. This is one cycle after the last data sample, with NOP in the cycles between.
- R6: During each WRITE, sdDqOe is 1 and sdDqOut carries the line word whose index equals the column's two low bits. sdBsN is the inverse of the request's byte enables during WRITE and is 0000 during READ. On a write, PALL comes D+4 cycles after ACTV, which is two cycles sooner than a read at latency field 01.
- R7: doneP is 1 exactly in the PALL cycle.
- R8: ACTV comes at least G+1 cycles after the previous PALL, where G is cfgPreGap sampled in that PALL cycle. A request accepted in the PALL cycle gets its ACTV exactly G+1 cycles after it.
- R9: reqReady is 1 only while idle and in the PALL cycle. A request is accepted when reqValid and reqReady are both 1 at a clock edge.
- R10: sdDqOe is 0 in every cycle that is not a WRITE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| latField | input | 2 | Latency field, sampled when a request is accepted |
| cfgPreGap | input | 2 | Precharge-to-activate gap in cycles, sampled at PALL |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request can be accepted |
| reqWrite | input | 1 | 1 = write line, 0 = read line |
| reqAddr | input | 24 | Byte address; [23:10] row, [9:2] column |
| reqByteEn | input | 4 | Byte enables for all write beats |
| reqWdata | input | 128 | Write line, word i in bits [32i+31:32i] |
| rdValid | output | 1 | Read beat valid |
| rdData | output | 32 | Read beat data |
| doneP | output | 1 | Burst completion pulse (PALL cycle) |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdAddr | output | 14 | Multiplexed row/column address |
| sdBsN | output | 4 | Byte strobes, active low |
| sdDqOut | output | 32 | Write data to the SDRAM |
| sdDqOe | output | 1 | Write data output enable |
| sdDqIn | input | 32 | Read data from the SDRAM |

## Verification
The bench runs every latency field value. It includes field 11, where a sequencer that added one without saturating would count a zero delay. It also uses start words 1, 2 and 3, so that a column counter that carries into bit 2 instead of wrapping would read from the next line. A simple SDRAM model returns address-derived data after exactly D cycles, so a capture tap that is off by one returns the neighbouring beat or a stale word. Back-to-back requests with gaps 0 and 3 check that the activate lands exactly G+1 cycles after the precharge, which catches both an ignored gap and a gap counted one cycle long. A read pipeline that was not cleared across a change of latency would produce a spurious beat.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  localparam int LINE_BEATS = 4;
  localparam int BEAT_W = $clog2(LINE_BEATS);
  localparam int LAT_W = 2;

  typedef enum logic [3:0] {
    CMD_ACTV  = 4'b0011,
    CMD_READ  = 4'b0101,
    CMD_WRITE = 4'b0100,
    CMD_PALL  = 4'b0010,
    CMD_NOP   = 4'b0111
  } sdCmd_e;

  typedef struct packed {
    sdCmd_e            cmd;
    logic              load;
    logic [BEAT_W-1:0] beat;
    logic [LAT_W-1:0]  latD;
  } seqStrb_t;

  function automatic logic [LAT_W-1:0] latFromField(input logic [LAT_W-1:0] f);
    return (f == 2'b11) ? 2'd3 : f + 2'd1;
  endfunction
endpackage

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LAT_W-1:0] latField,
  input  logic [1:0]       cfgPreGap,
  output logic             reqReady,
  output logic             doneP,
  output seqStrb_t         strb
);
  typedef enum logic [2:0] {S_IDLE, S_ARM, S_RCD, S_COL, S_TAIL, S_PRE} seqState_e;

  seqState_e         state;
  logic [LAT_W-1:0]  cnt;
  logic [LAT_W-1:0]  latD;
  logic [BEAT_W-1:0] beat;
  logic [1:0]        gapCnt;
  logic              isWr;
  logic              accept;
  logic              gapDone;

  assign reqReady = (state == S_IDLE) || (state == S_PRE);
  assign accept   = reqValid && reqReady;
  assign gapDone  = (gapCnt == 2'd0);
  assign doneP    = (state == S_PRE);

  // precharge-to-activate window counter, loaded in the PALL cycle
  always_ff @(posedge clk) begin
    if (!rstN) gapCnt <= 2'd0;
    else if (state == S_PRE) gapCnt <= cfgPreGap;
    else if (!gapDone) gapCnt <= gapCnt - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      latD  <= 2'd1;
      beat  <= '0;
      isWr  <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_PRE: begin
          if (accept) begin
            state <= S_ARM;
            latD  <= latFromField(latField);
            isWr  <= reqWrite;
          end else begin
            state <= S_IDLE;
          end
        end
        S_ARM: begin
          if (gapDone) begin
            beat <= '0;
            if (latD == 2'd1) state <= S_COL;
            else begin
              state <= S_RCD;
              cnt   <= latD - 2'd2;
            end
          end
        end
        S_RCD: begin
          if (cnt == '0) state <= S_COL;
          else cnt <= cnt - 2'd1;
        end
        S_COL: begin
          beat <= beat + 1'b1;
          if (beat == BEAT_W'(LINE_BEATS - 1)) begin
            if (isWr) state <= S_PRE;
            else begin
              state <= S_TAIL;
              cnt   <= latD - 2'd1;
            end
          end
        end
        S_TAIL: begin
          if (cnt == '0) state <= S_PRE;
          else cnt <= cnt - 2'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load = accept;
    strb.beat = beat;
    strb.latD = latD;
    case (state)
      S_ARM:   strb.cmd = gapDone ? CMD_ACTV : CMD_NOP;
      S_COL:   strb.cmd = isWr ? CMD_WRITE : CMD_READ;
      S_PRE:   strb.cmd = CMD_PALL;
      default: strb.cmd = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/sdram_seq_dp.sv
module sdram_seq_dp
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 32,
  parameter int COL_BITS = 8,
  parameter int SDA_W    = 14,
  parameter int AP_BIT   = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seqStrb_t                     strb,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [DATA_W/8-1:0]          reqByteEn,
  input  logic [DATA_W*LINE_BEATS-1:0] reqWdata,
  input  logic [DATA_W-1:0]            sdDqIn,
  output logic [SDA_W-1:0]             sdAddr,
  output logic [DATA_W/8-1:0]          sdBsN,
  output logic [DATA_W-1:0]            sdDqOut,
  output logic                         sdDqOe,
  output logic                         rdValid,
  output logic [DATA_W-1:0]            rdData
);
  localparam int BE_W     = DATA_W / 8;
  localparam int ROW_BITS = ADDR_W - COL_BITS - 2;
  localparam int LINE_W   = DATA_W * LINE_BEATS;
  localparam int MAX_LAT  = 3;

  logic [ROW_BITS-1:0] rowQ;
  logic [COL_BITS-1:0] colQ;
  logic [BE_W-1:0]     beQ;
  logic [LINE_W-1:0]   lineQ;
  logic [COL_BITS-1:0] colNow;
  logic [MAX_LAT-1:0]  rdPipe;
  logic                capTap;
  logic                unusedAddrBits;

  assign unusedAddrBits = ^reqAddr[1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ  <= '0;
      colQ  <= '0;
      beQ   <= '0;
      lineQ <= '0;
    end else if (strb.load) begin
      rowQ  <= reqAddr[ADDR_W-1:COL_BITS+2];
      colQ  <= reqAddr[COL_BITS+1:2];
      beQ   <= reqByteEn;
      lineQ <= reqWdata;
    end
  end

  // column wraps inside the line: only the beat bits advance
  assign colNow = {colQ[COL_BITS-1:BEAT_W], colQ[BEAT_W-1:0] + strb.beat};

  always_comb begin
    case (strb.cmd)
      CMD_ACTV:            sdAddr = SDA_W'(rowQ);
      CMD_READ, CMD_WRITE: sdAddr = SDA_W'(colNow);
      CMD_PALL:            sdAddr = SDA_W'(1) << AP_BIT;
      default:             sdAddr = '0;
    endcase
  end

  assign sdDqOe  = (strb.cmd == CMD_WRITE);
  assign sdDqOut = sdDqOe ? lineQ[int'(colNow[BEAT_W-1:0]) * DATA_W +: DATA_W] : '0;

  always_comb begin
    case (strb.cmd)
      CMD_WRITE: sdBsN = ~beQ;
      CMD_READ:  sdBsN = '0;
      default:   sdBsN = '1;
    endcase
  end

  // read-issue delay line; the tap at D-1 marks the data sampling cycle
  always_ff @(posedge clk) begin
    if (!rstN || strb.load) rdPipe[0] <= 1'b0;
    else rdPipe[0] <= (strb.cmd == CMD_READ);
  end

  for (genvar s = 1; s < MAX_LAT; s++) begin : g_rdStage
    always_ff @(posedge clk) begin
      if (!rstN || strb.load) rdPipe[s] <= 1'b0;
      else rdPipe[s] <= rdPipe[s-1];
    end
  end

  assign capTap = rdPipe[strb.latD - 2'd1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= capTap;
      if (capTap) rdData <= sdDqIn;
    end
  end
endmodule

// File: rtl/sdram_line_seq.sv
module sdram_line_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 32,
  parameter int COL_BITS = 8,
  parameter int SDA_W    = 14,
  parameter int AP_BIT   = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   latField,
  input  logic [1:0]                   cfgPreGap,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic                         reqWrite,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [DATA_W/8-1:0]          reqByteEn,
  input  logic [DATA_W*LINE_BEATS-1:0] reqWdata,
  output logic                         rdValid,
  output logic [DATA_W-1:0]            rdData,
  output logic                         doneP,
  output logic                         sdCsN,
  output logic                         sdRasN,
  output logic                         sdCasN,
  output logic                         sdWeN,
  output logic [SDA_W-1:0]             sdAddr,
  output logic [DATA_W/8-1:0]          sdBsN,
  output logic [DATA_W-1:0]            sdDqOut,
  output logic                         sdDqOe,
  input  logic [DATA_W-1:0]            sdDqIn
);
  seqStrb_t strb;

  sdram_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .latField(latField), .cfgPreGap(cfgPreGap), .reqReady(reqReady),
    .doneP(doneP), .strb(strb)
  );

  sdram_seq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_BITS(COL_BITS),
    .SDA_W(SDA_W), .AP_BIT(AP_BIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqByteEn(reqByteEn), .reqWdata(reqWdata), .sdDqIn(sdDqIn),
    .sdAddr(sdAddr), .sdBsN(sdBsN), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe),
    .rdValid(rdValid), .rdData(rdData)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = strb.cmd;
endmodule

// File: rtl/sdram_line_seq_chk.sv
module sdram_line_seq_chk #(
  parameter int SDA_W  = 14,
  parameter int AP_BIT = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       cfgPreGap,
  input logic             sdCsN,
  input logic             sdRasN,
  input logic             sdCasN,
  input logic             sdWeN,
  input logic [SDA_W-1:0] sdAddr,
  input logic             sdDqOe,
  input logic             doneP,
  input logic             reqReady
);
  logic [3:0] cmd;
  logic [2:0] sincePall;
  logic [1:0] gapHeld;

  assign cmd = {sdCsN, sdRasN, sdCasN, sdWeN};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sincePall <= 3'd7;
      gapHeld   <= 2'd0;
    end else if (cmd == 4'b0010) begin
      sincePall <= 3'd0;
      gapHeld   <= cfgPreGap;
    end else if (sincePall != 3'd7) begin
      sincePall <= sincePall + 3'd1;
    end
  end

  // R8
  pre_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 4'b0011) |-> (sincePall >= {1'b0, gapHeld}));

  // R5
  pall_ap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 4'b0010) |-> (sdAddr == (SDA_W'(1) << AP_BIT)));

  // R7
  done_pall_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneP == (cmd == 4'b0010));

  // R10
  oe_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdDqOe == (cmd == 4'b0100));

  // R3
  legal_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd inside {4'b0011, 4'b0101, 4'b0100, 4'b0010, 4'b0111});

  // R2
  actv_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 4'b0011) |=> (cmd != 4'b0011));

  // R9
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd inside {4'b0011, 4'b0101, 4'b0100}) |-> !reqReady);
endmodule

bind sdram_line_seq sdram_line_seq_chk #(.SDA_W(SDA_W), .AP_BIT(AP_BIT)) chk_i (.*);

// File: tb/sdram_line_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_line_seq_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   latField = 2'b01;
  logic [1:0]   cfgPreGap = 2'd1;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic         reqWrite = 1'b0;
  logic [23:0]  reqAddr = '0;
  logic [3:0]   reqByteEn = '0;
  logic [127:0] reqWdata = '0;
  logic         rdValid;
  logic [31:0]  rdData;
  logic         doneP;
  logic         sdCsN, sdRasN, sdCasN, sdWeN;
  logic [13:0]  sdAddr;
  logic [3:0]   sdBsN;
  logic [31:0]  sdDqOut;
  logic         sdDqOe;
  logic [31:0]  sdDqIn = '0;

  always #4 clk = ~clk;

  sdram_line_seq dut_i (.*);

  typedef struct {
    bit           wr;
    int           d;
    logic [13:0]  row;
    logic [7:0]   col;
    logic [3:0]   be;
    logic [127:0] wdata;
  } reqDesc_t;

  reqDesc_t    descQ[$];
  logic [31:0] expQ[$];
  reqDesc_t    cur;
  int nChecks = 0, nFail = 0, cyc = 0;
  int actCyc = 0, curD = 1, lastPall = -1, lastGap = 0, lastDist = 0, rdBeat = 0;
  logic [13:0] rowActv = '0;
  logic [31:0] slot[8];
  bit finished = 0;

  function automatic logic [31:0] memWord(input logic [13:0] row, input logic [7:0] col);
    return {2'b10, row, col, 8'h5A};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc++;

  // monitor: SDRAM model plus scoreboard
  always @(negedge clk) begin
    logic [3:0] cmd;
    logic [7:0] eCol;
    int k;
    cmd = {sdCsN, sdRasN, sdCasN, sdWeN};
    if (rstN) begin
      case (cmd)
        4'b0011: begin
          if (descQ.size() == 0) chk(0, "R9 unexpected ACTV", 1, 0);
          else begin
            cur = descQ.pop_front();
            curD = cur.d; actCyc = cyc; rdBeat = 0; rowActv = sdAddr;
            chk(sdAddr == cur.row, "R2 row", sdAddr, cur.row);
            chk(!reqReady, "R9 ready while busy", reqReady, 0);
            if (lastPall >= 0) begin
              lastDist = cyc - lastPall;
              chk(lastDist >= lastGap + 1, "R8 gap", lastDist, lastGap + 1);
            end
          end
        end
        4'b0101, 4'b0100: begin
          k = cyc - actCyc - curD;
          chk(k >= 0 && k < 4, "R2 column timing", k, 0);
          chk((cmd == 4'b0100) == cur.wr, "R3 column command type", cmd, cur.wr ? 4 : 5);
          eCol = {cur.col[7:2], 2'(cur.col[1:0] + 2'(k))};
          chk(sdAddr == {6'd0, eCol}, "R3 column address", sdAddr, eCol);
          if (cmd == 4'b0100) begin
            chk(sdDqOe, "R6 oe on write", sdDqOe, 1);
            chk(sdDqOut == cur.wdata[eCol[1:0]*32 +: 32], "R6 write data", sdDqOut, cur.wdata[eCol[1:0]*32 +: 32]);
            chk(sdBsN == ~cur.be, "R6 write strobes", sdBsN, ~cur.be);
          end else begin
            chk(!sdDqOe, "R10 oe on read", sdDqOe, 0);
            chk(sdBsN == 4'b0000, "R6 read strobes", sdBsN, 0);
            slot[(cyc + curD) % 8] = memWord(rowActv, sdAddr[7:0]);
          end
        end
        4'b0010: begin
          chk(cyc - actCyc == (cur.wr ? curD + 4 : 2 * curD + 4), "R5/R6 precharge timing",
              cyc - actCyc, cur.wr ? curD + 4 : 2 * curD + 4);
          chk(sdAddr == 14'h0400, "R5 precharge address", sdAddr, 14'h0400);
          chk(doneP, "R7 done in PALL", doneP, 1);
          chk(reqReady, "R9 ready in PALL", reqReady, 1);
          lastPall = cyc; lastGap = int'(cfgPreGap);
        end
        4'b0111: begin
          if (sdDqOe || doneP) chk(0, "R10/R7 idle outputs", {sdDqOe, doneP}, 0);
        end
        default: chk(0, "R3 illegal command", cmd, 4'b0111);
      endcase
      if (rdValid) begin
        if (expQ.size() == 0) chk(0, "R4 unexpected read beat", rdData, 0);
        else begin
          logic [31:0] w;
          w = expQ.pop_front();
          chk(rdData == w, "R4 read data", rdData, w);
          chk(cyc == actCyc + 2 * curD + rdBeat + 1, "R4 read beat timing", cyc, actCyc + 2 * curD + rdBeat + 1);
          rdBeat++;
        end
      end
    end
    sdDqIn = slot[cyc % 8];
    slot[cyc % 8] = 32'hDEAD_BEEF;
  end

  task automatic doReq(input bit wr, input logic [13:0] row, input logic [7:0] col,
                       input logic [1:0] lat, input logic [3:0] be, input logic [127:0] wd);
    reqDesc_t d;
    reqValid = 1'b1; reqWrite = wr; reqAddr = {row, col, 2'b00};
    latField = lat; reqByteEn = be; reqWdata = wd;
    while (!reqReady) @(negedge clk);
    d.wr = wr; d.d = (lat == 2'b11) ? 3 : int'(lat) + 1;
    d.row = row; d.col = col; d.be = be; d.wdata = wd;
    descQ.push_back(d);
    if (!wr)
      for (int k = 0; k < 4; k++)
        expQ.push_back(memWord(row, {col[7:2], 2'(col[1:0] + 2'(k))}));
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!(reqReady && descQ.size() == 0 && expQ.size() == 0)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) slot[i] = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({sdCsN, sdRasN, sdCasN, sdWeN} == 4'b0111, "R1 idle command", {sdCsN, sdRasN, sdCasN, sdWeN}, 4'b0111);
    chk(reqReady, "R1 ready", reqReady, 1);
    chk(!sdDqOe && !rdValid && !doneP, "R1 quiet outputs", {sdDqOe, rdValid, doneP}, 0);

    cfgPreGap = 2'd1;
    doReq(0, 14'h0123, 8'h10, 2'b01, 4'hF, '0); waitIdle();
    doReq(0, 14'h2ABC, 8'h42, 2'b00, 4'hF, '0); waitIdle();
    doReq(0, 14'h1111, 8'h83, 2'b10, 4'hF, '0); waitIdle();
    doReq(0, 14'h3FFF, 8'hFD, 2'b11, 4'hF, '0); waitIdle();
    doReq(1, 14'h0456, 8'h21, 2'b01, 4'b1010,
          128'h44444444_33333333_22222222_11111111); waitIdle();
    doReq(1, 14'h0789, 8'h07, 2'b00, 4'b0110,
          128'hDDDD0004_CCCC0003_BBBB0002_AAAA0001); waitIdle();

    // R8 back-to-back, gap 3
    cfgPreGap = 2'd3;
    doReq(0, 14'h0AAA, 8'h12, 2'b11, 4'hF, '0);
    doReq(1, 14'h0BBB, 8'h33, 2'b00, 4'b0001, 128'h0F0E0D0C_0B0A0908_07060504_03020100);
    waitIdle();
    chk(lastDist == 4, "R8 exact gap 3", lastDist, 4);

    // R8 back-to-back, gap 0, latency change between bursts
    cfgPreGap = 2'd0;
    doReq(1, 14'h0CCC, 8'h02, 2'b10, 4'hF, 128'h1234);
    doReq(0, 14'h0DDD, 8'h01, 2'b00, 4'hF, '0);
    waitIdle();
    chk(lastDist == 1, "R8 exact gap 0", lastDist, 1);
    doReq(0, 14'h0EEE, 8'h0E, 2'b01, 4'hF, '0);
    doReq(0, 14'h0FFF, 8'h0B, 2'b11, 4'hF, '0);
    waitIdle();
    chk(expQ.size() == 0 && descQ.size() == 0, "R4 scoreboard drained", expQ.size(), 0);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    finishRun();
  end
endmodule